// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits between a bank of timer channels and the interrupt fabric. Each channel reports expiry with a one-cycle pulse. The router turns that pulse into one of three things, depending on the channel's settings: a held level on a chosen interrupt line, a one-cycle pulse on that line, or a message write on a valid/ready port. The block keeps a per-channel status register for level-mode channels. Software clears this register by writing 1 to a bit.

A legacy mode makes the router stand in for two older interrupt sources, an interval timer and a real-time clock. Outside legacy mode, both sources pass through to lines 0 and 8. In legacy mode, the sources are masked, channel 0 takes line 0 and channel 1 takes line 8. An enable output tells the interval timer whether it still owns its line. Lines numbered 16 and above feed active-low inputs, so the router drives them inverted.

Top module: `timer_irq_router`

## Requirements
- R1: Outside legacy mode, a channel drives the line chosen by its route field. The route field of channel c is `ch_route_i[c*5 +: 5]`.
- R2: An expiry on an active level-mode channel (`ch_level_i`=1) sets its status bit one cycle after the expiry. Two cycles after the expiry, the line is asserted, and it stays asserted until the status bit is cleared. An edge-mode channel asserts its line for exactly one cycle, two cycles after the expiry, and never sets its status bit.
- R3: Lines 16 and above are active-low. After reset `irq_o` is 32'hFFFF0000, and asserting such a line drives it to 0.
- R4: When `sts_wr_i` is 1, each 1 in `sts_wdata_i` clears that status bit, and the line deasserts on the next cycle. A 0 in `sts_wdata_i` leaves its bit unchanged.
- R5: When a channel's enable or the global enable is 0, the channel's status is cleared, its expiries are ignored and its line is deasserted.
- R6: When a channel has message delivery enabled, an expiry sends a message instead of asserting the line. The message address is bits 63:32 of the channel's 64-bit word `ch_msg_i[c*64 +: 64]`, and the message data is bits 31:0. Enabling message delivery clears the status bit and releases the line.
- R7: A message stays on the port with stable address and data until `msg_ready_i` accepts it. Pending channels are served lowest index first. Repeated expiries of a channel that has not yet been served produce one message.
- R8: Outside legacy mode, line 0 follows `pit_i` one cycle later, and line 8 follows the recorded `rtc_i` level two cycles later. The router records the `rtc_i` level in every mode.
- R9: In legacy mode (`legacy_i`=1), channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold. The two legacy sources are masked, and `pit_en_o` goes to 0. Leaving legacy mode sets `pit_en_o` back to 1 and gives line 8 the recorded clock level.
- R10: When two channels route to the same line, the line is asserted while either channel asserts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| expire_i | input | NUM_CH | Per-channel expiry pulse |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_level_i | input | NUM_CH | 1 = level mode, 0 = edge mode |
| ch_msg_en_i | input | NUM_CH | Deliver by message write instead of a line |
| ch_route_i | input | NUM_CH*5 | Packed line number per channel |
| ch_msg_i | input | NUM_CH*64 | Per-channel message word: address high, data low |
| glb_en_i | input | 1 | Global enable |
| legacy_i | input | 1 | Legacy replacement mode |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | NUM_CH | Write-1-to-clear mask |
| pit_i | input | 1 | Legacy interval-timer interrupt |
| rtc_i | input | 1 | Legacy real-time-clock interrupt level |
| msg_ready_i | input | 1 | Message sink ready |
| irq_o | output | 32 | Interrupt lines; lines 16 and above are active-low |
| sts_o | output | NUM_CH | Status register |
| msg_valid_o | output | 1 | Message valid |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |
| pit_en_o | output | 1 | Interval-timer enable |

## Verification
The hardest case to reach is the message path while the sink is stalled. Two channels must be waiting at once, and one of them must expire again before it is served. The bench holds `msg_ready_i` low and expires two message channels in the same cycle. It then re-expires the later channel twice, and only then opens the sink. The scoreboard expects exactly two messages, in index order. Legacy restore is reached by changing the clock input while legacy mode masks it, so the line 8 value after exit can only come from the recorded level.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;
  localparam int unsigned MSG_W  = 64;
  localparam int unsigned HALF_W = 32;

  typedef struct packed {
    logic [HALF_W-1:0] addr;
    logic [HALF_W-1:0] data;
  } msg_t;

  function automatic logic [31:0] low_inv_mask(input int unsigned lines,
                                               input int unsigned base);
    logic [31:0] m;
    m = '0;
    for (int unsigned l = 0; l < 32; l++) begin
      if (l < lines && l >= base) m[l] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/timer_irq_chan.sv
module timer_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic active_i,
  input  logic level_i,
  input  logic msg_en_i,
  input  logic clr_i,
  output logic sts_o,
  output logic line_req_o,
  output logic msg_req_o
);
  logic sts_q, pulse_q, fire;

  assign fire = expire_i & active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (!active_i || msg_en_i)     sts_q <= 1'b0;
      else if (fire && level_i)      sts_q <= 1'b1;  // set beats clear
      else if (clr_i)                sts_q <= 1'b0;
      pulse_q <= fire & ~msg_en_i & ~level_i;
    end
  end

  assign sts_o      = sts_q;
  assign line_req_o = sts_q | pulse_q;
  assign msg_req_o  = fire & msg_en_i;
endmodule

// File: rtl/timer_irq_lines.sv
module timer_irq_lines #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ROUTE_W   = 5,
  parameter int unsigned LEG_A     = 0,
  parameter int unsigned LEG_B     = 8,
  parameter int unsigned INV_BASE  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CH-1:0]           req_i,
  input  logic [NUM_CH*ROUTE_W-1:0]   route_i,
  input  logic                        legacy_i,
  input  logic                        pit_i,
  input  logic                        rtc_lvl_i,
  output logic [NUM_LINES-1:0]        irq_o
);
  import timer_irq_pkg::*;

  localparam logic [31:0] INV_FULL = low_inv_mask(NUM_LINES, INV_BASE);
  localparam logic [NUM_LINES-1:0] INV_MASK = INV_FULL[NUM_LINES-1:0];

  logic [NUM_LINES-1:0] hit, irq_q;
  logic [ROUTE_W-1:0]   dest [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dest
    if (c == 0) begin : g_leg_a
      assign dest[c] = legacy_i ? ROUTE_W'(LEG_A) : route_i[c*ROUTE_W +: ROUTE_W];
    end else if (c == 1) begin : g_leg_b
      assign dest[c] = legacy_i ? ROUTE_W'(LEG_B) : route_i[c*ROUTE_W +: ROUTE_W];
    end else begin : g_plain
      assign dest[c] = route_i[c*ROUTE_W +: ROUTE_W];
    end
  end

  always_comb begin
    hit = '0;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (req_i[c] && (int'(dest[c]) < int'(NUM_LINES))) hit[dest[c]] = 1'b1;
    end
    if (!legacy_i) begin
      hit[LEG_A] = hit[LEG_A] | pit_i;
      hit[LEG_B] = hit[LEG_B] | rtc_lvl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= INV_MASK;
    else         irq_q <= hit ^ INV_MASK;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/timer_irq_msgq.sv
module timer_irq_msgq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_CH-1:0]                     req_i,
  input  logic [NUM_CH*timer_irq_pkg::MSG_W-1:0] msg_i,
  input  logic                                  ready_i,
  output logic                                  valid_o,
  output timer_irq_pkg::msg_t                   msg_o
);
  import timer_irq_pkg::*;

  logic [NUM_CH-1:0] pend_q, grant;
  logic              load, valid_q;
  msg_t              sel, msg_q;

  always_comb begin
    grant = '0;
    sel   = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pend_q[c]) begin
        grant    = '0;
        grant[c] = 1'b1;
        sel      = msg_i[c*MSG_W +: MSG_W];
      end
    end
  end

  assign load = (|pend_q) && (!valid_q || ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~(load ? grant : '0)) | req_i;
      if (load) begin
        valid_q <= 1'b1;
        msg_q   <= sel;
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign msg_o   = msg_q;
endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned LEG_A     = 0,
  parameter int unsigned LEG_B     = 8,
  parameter int unsigned INV_BASE  = 16,
  localparam int unsigned ROUTE_W  = $clog2(NUM_LINES),
  localparam int unsigned MSG_W    = timer_irq_pkg::MSG_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH-1:0]         expire_i,
  input  logic [NUM_CH-1:0]         ch_en_i,
  input  logic [NUM_CH-1:0]         ch_level_i,
  input  logic [NUM_CH-1:0]         ch_msg_en_i,
  input  logic [NUM_CH*ROUTE_W-1:0] ch_route_i,
  input  logic [NUM_CH*MSG_W-1:0]   ch_msg_i,
  input  logic                      glb_en_i,
  input  logic                      legacy_i,
  input  logic                      sts_wr_i,
  input  logic [NUM_CH-1:0]         sts_wdata_i,
  input  logic                      pit_i,
  input  logic                      rtc_i,
  input  logic                      msg_ready_i,
  output logic [NUM_LINES-1:0]      irq_o,
  output logic [NUM_CH-1:0]         sts_o,
  output logic                      msg_valid_o,
  output logic [31:0]               msg_addr_o,
  output logic [31:0]               msg_data_o,
  output logic                      pit_en_o
);
  import timer_irq_pkg::*;

  logic [NUM_CH-1:0] line_req, msg_req, clr;
  logic              rtc_q, pit_en_q;
  msg_t              msg;

  assign clr = sts_wr_i ? sts_wdata_i : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    timer_irq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .expire_i   (expire_i[c]),
      .active_i   (ch_en_i[c] & glb_en_i),
      .level_i    (ch_level_i[c]),
      .msg_en_i   (ch_msg_en_i[c]),
      .clr_i      (clr[c]),
      .sts_o      (sts_o[c]),
      .line_req_o (line_req[c]),
      .msg_req_o  (msg_req[c])
    );
  end

  // clock level is recorded in every mode so exit from legacy restores it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtc_q    <= 1'b0;
      pit_en_q <= 1'b1;
    end else begin
      rtc_q    <= rtc_i;
      pit_en_q <= ~legacy_i;
    end
  end
  assign pit_en_o = pit_en_q;

  timer_irq_lines #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES),
    .ROUTE_W   (ROUTE_W),
    .LEG_A     (LEG_A),
    .LEG_B     (LEG_B),
    .INV_BASE  (INV_BASE)
  ) u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (line_req),
    .route_i   (ch_route_i),
    .legacy_i  (legacy_i),
    .pit_i     (pit_i),
    .rtc_lvl_i (rtc_q),
    .irq_o     (irq_o)
  );

  timer_irq_msgq #(.NUM_CH(NUM_CH)) u_msgq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (msg_req),
    .msg_i   (ch_msg_i),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .msg_o   (msg)
  );

  assign msg_addr_o = msg.addr;
  assign msg_data_o = msg.data;
endmodule

// File: rtl/timer_irq_router_chk.sv
module timer_irq_router_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              glb_en_i,
  input logic              legacy_i,
  input logic              sts_wr_i,
  input logic [NUM_CH-1:0] sts_wdata_i,
  input logic [NUM_CH-1:0] expire_i,
  input logic [NUM_CH-1:0] ch_level_i,
  input logic [NUM_CH-1:0] sts_o,
  input logic              pit_en_o,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [31:0]       msg_addr_o,
  input logic [31:0]       msg_data_o
);
  assert_glb_off_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> (sts_o == '0));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_i |=> ((sts_o & $past(sts_wdata_i & ~expire_i)) == '0));

  assert_edge_no_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_o & ~$past(sts_o) & ~$past(ch_level_i)) == '0));

  assert_legacy_pit_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i |=> !pit_en_o);

  assert_legacy_pit_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy_i |=> pit_en_o);

  assert_msg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));
endmodule

bind timer_irq_router timer_irq_router_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .glb_en_i    (glb_en_i),
  .legacy_i    (legacy_i),
  .sts_wr_i    (sts_wr_i),
  .sts_wdata_i (sts_wdata_i),
  .expire_i    (expire_i),
  .ch_level_i  (ch_level_i),
  .sts_o       (sts_o),
  .pit_en_o    (pit_en_o),
  .msg_valid_o (msg_valid_o),
  .msg_ready_i (msg_ready_i),
  .msg_addr_o  (msg_addr_o),
  .msg_data_o  (msg_data_o)
);

// File: tb/timer_irq_router_test.sv
module timer_irq_router_test;
  localparam int NCH = 4;
  localparam int RW  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    expire = '0, ch_en = '0, ch_level = '0, ch_msg_en = '0;
  logic [NCH*RW-1:0] ch_route = '0;
  logic [NCH*64-1:0] ch_msg = '0;
  logic              glb_en = 1'b0, legacy = 1'b0, sts_wr = 1'b0;
  logic [NCH-1:0]    sts_wdata = '0;
  logic              pit = 1'b0, rtc = 1'b0, msg_ready = 1'b0;
  logic [31:0]       irq;
  logic [NCH-1:0]    sts;
  logic              msg_valid, pit_en;
  logic [31:0]       msg_addr, msg_data;

  always #2 clk = ~clk;

  timer_irq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .expire_i(expire), .ch_en_i(ch_en),
    .ch_level_i(ch_level), .ch_msg_en_i(ch_msg_en), .ch_route_i(ch_route),
    .ch_msg_i(ch_msg), .glb_en_i(glb_en), .legacy_i(legacy), .sts_wr_i(sts_wr),
    .sts_wdata_i(sts_wdata), .pit_i(pit), .rtc_i(rtc), .msg_ready_i(msg_ready),
    .irq_o(irq), .sts_o(sts), .msg_valid_o(msg_valid), .msg_addr_o(msg_addr),
    .msg_data_o(msg_data), .pit_en_o(pit_en)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; } exp_msg_t;
  exp_msg_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    expire = m; step(1); expire = '0;
  endtask

  task automatic w1c(input logic [NCH-1:0] m);
    sts_wr = 1'b1; sts_wdata = m; step(1); sts_wr = 1'b0; sts_wdata = '0;
  endtask

  task automatic push_msg(input int c);
    exp_msg_t e;
    e.a = ch_msg[c*64+32 +: 32];
    e.d = ch_msg[c*64 +: 32];
    exp_q.push_back(e);
  endtask

  // scoreboard monitor: inputs change only just after posedge
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected message", {msg_addr, msg_data}, 64'h0);
      end else begin
        exp_msg_t e;
        e = exp_q.pop_front();
        check("R6 message word", {msg_addr, msg_data}, {e.a, e.d});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R3 reset lines", irq, 32'hFFFF0000);
    check("R2 reset status", sts, 0);
    check("R9 reset pit enable", pit_en, 1);
    check("R7 reset valid", msg_valid, 0);
    rst_n = 1'b1;

    glb_en = 1; ch_en = '1; ch_level = 4'b0111;
    ch_route[0*RW +: RW] = 5; ch_route[1*RW +: RW] = 5;
    ch_route[2*RW +: RW] = 3; ch_route[3*RW +: RW] = 20;
    step(1);

    // level channel
    fire(4'b0100);
    check("R2 status set", sts, 4'b0100);
    step(1);
    check("R1 route line 3", irq[3], 1);
    step(3);
    check("R2 level held", irq[3], 1);

    // write-1-to-clear
    w1c(4'b1011); step(1);
    check("R4 zero bit no effect status", sts[2], 1);
    check("R4 zero bit no effect line", irq[3], 1);
    w1c(4'b0100);
    check("R4 status cleared", sts, 0);
    step(1);
    check("R4 line released", irq[3], 0);

    // edge channel on inverted line
    fire(4'b1000);
    check("R2 edge no status", sts, 0);
    step(1);
    check("R3 inverted pulse low", irq[20], 0);
    step(1);
    check("R2 edge pulse one cycle", irq[20], 1);

    // shared line
    fire(4'b0011); step(1);
    check("R10 shared asserted", irq[5], 1);
    w1c(4'b0001); step(1);
    check("R10 other still holds", irq[5], 1);
    w1c(4'b0010); step(1);
    check("R10 shared released", irq[5], 0);

    // channel and global disable
    fire(4'b0100); step(1);
    ch_en[2] = 0; step(1);
    check("R5 channel off status", sts[2], 0);
    step(1);
    check("R5 channel off line", irq[3], 0);
    ch_en[2] = 1;
    fire(4'b0100); step(1);
    glb_en = 0; step(2);
    check("R5 global off status", sts, 0);
    check("R5 global off line", irq[3], 0);
    fire(4'b0100); step(1);
    check("R5 expiry ignored", {sts, irq[3]}, 0);
    glb_en = 1; step(1);

    // legacy sources pass through
    pit = 1; rtc = 1; step(2);
    check("R8 pit on line 0", irq[0], 1);
    check("R8 rtc on line 8", irq[8], 1);

    // legacy mode
    legacy = 1; step(1);
    check("R9 pit enable low", pit_en, 0);
    step(1);
    check("R9 line 0 masked", irq[0], 0);
    check("R9 line 8 masked", irq[8], 0);
    rtc = 0;
    fire(4'b0001); step(1);
    check("R9 ch0 on line 0", irq[0], 1);
    check("R9 ch0 route ignored", irq[5], 0);
    w1c(4'b0001);
    fire(4'b0010); step(1);
    check("R9 ch1 on line 8", irq[8], 1);
    w1c(4'b0010); step(1);
    legacy = 0; step(1);
    check("R9 pit enable restored", pit_en, 1);
    step(1);
    check("R8 pit back on line 0", irq[0], 1);
    check("R9 line 8 recorded level", irq[8], 0);
    rtc = 1; step(2);
    check("R8 rtc follows", irq[8], 1);
    pit = 0; rtc = 0; step(2);

    // enabling messages releases the line
    fire(4'b0100); step(1);
    check("R2 line before message enable", irq[3], 1);
    ch_msg_en[2] = 1; step(1);
    check("R6 msg enable clears status", sts[2], 0);
    step(1);
    check("R6 msg enable releases line", irq[3], 0);

    // messages under back-pressure
    ch_msg[1*64 +: 64] = 64'hFEE0_1000_0000_0031;
    ch_msg[2*64 +: 64] = 64'hFEE0_2000_0000_0042;
    ch_msg_en[1] = 1;
    push_msg(1); push_msg(2);
    fire(4'b0110); step(1);
    check("R7 first valid", msg_valid, 1);
    check("R7 lowest index first", msg_addr, 32'hFEE0_1000);
    check("R6 no line for message", {irq[3], irq[5], sts}, 0);
    fire(4'b0100); fire(4'b0100); step(1);
    check("R7 held while stalled", {msg_valid, msg_addr, msg_data}, {1'b1, 64'hFEE0_1000_0000_0031});
    msg_ready = 1; step(4);
    msg_ready = 0;
    check("R7 drained", msg_valid, 0);
    check("R7 coalesced count", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule